// File: doc/BRIEF.md
# Signaling NaN Quieting Converter

This unit sits beside the floating-point datapath and handles one narrow job. When an operand held in the internal extended-precision form is a NaN, the unit produces the value stored at the destination. An operand here is a sign, a 15-bit exponent and a 64-bit significand with an explicit integer bit. An arithmetic operation on a signaling NaN with its trap disabled gets a quieted NaN, reshaped to the destination format. If the trap is enabled, the unit suppresses the write and requests the trap instead. In both cases the sticky signaling-NaN status flag is raised.

The destination format is a 3-bit code. Every result is left-justified in a 96-bit bus. Non-arithmetic moves (register moves, control-register writes, state saves) copy a NaN's bits without quieting it and never touch the status flag or the trap. Non-NaN operands belong to the ordinary arithmetic path, so the unit raises no strobe for them. All outputs are registered, with a latency of one cycle.

Top module: `nan_quiet_unit`

## Requirements
- R1: An operand is a signaling NaN when its exponent is all ones, significand bit 62 (quiet bit) is 0 and bits 61..0 are not all zero; bit 63 (integer bit) is ignored. It is a NaN when the exponent is all ones and bits 62..0 are nonzero. A non-NaN operand produces no `res_valid`.
- R2: Floating destinations are encoded as single=1, double=5, extended=2, packed=3 and reserved 7, where packed and reserved are treated like extended. In these formats an arithmetic NaN result has the quiet bit forced to 1 and every other kept bit unchanged, and the low fraction bits are truncated. The layouts from bit 95 down are: single {sign, 8 ones, significand[62:40]}; double {sign, 11 ones, significand[62:11]}; extended {sign, exponent, 16 zeros, significand[63:0]}. All unused low bits are zero.
- R3: Integer destinations are encoded as long=0, word=4 and byte=6. They receive the top 32, 16 or 8 significand bits, with bit 62 forced to 1, at bits 95 downward. The remaining bits are zero.
- R4: A quiet NaN operand is converted in the same way and never raises the status flag or the trap.
- R5: `snan_sticky` rises one cycle after an arithmetic operation on a signaling NaN. It stays set until `clr_status` is asserted, and it is cleared one cycle later. If a set and a clear arrive in the same cycle, the set wins.
- R6: A non-arithmetic move (`arith_op`=0) copies the NaN bits without forcing the quiet bit, still truncating them. It never changes `snan_sticky` and never asserts `trap_req`.
- R7: When `snan_trap_en`=1 and an arithmetic operation meets a signaling NaN, `trap_req` is high for exactly one cycle and `res_valid` stays low. The status flag is still set.
- R8: `res_valid`, `res_data` and `trap_req` appear exactly one cycle after the accepting `in_valid`. `res_valid` and `trap_req` are single-cycle pulses.
- R9: No result of an arithmetic operation is a signaling NaN: its quiet bit is always 1.
- R10: After reset, `res_valid`, `trap_req`, `snan_sticky` and `res_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| op_sign | input | 1 | Operand sign |
| op_exp | input | 15 | Operand biased exponent |
| op_sig | input | 64 | Operand significand, integer bit at 63 |
| dst_fmt | input | 3 | Destination format code |
| arith_op | input | 1 | 1 = arithmetic operation, 0 = status-preserving move |
| snan_trap_en | input | 1 | Signaling-NaN trap enable |
| clr_status | input | 1 | Clears the sticky status flag |
| res_data | output | 96 | Left-justified destination value |
| res_valid | output | 1 | Destination write strobe |
| snan_sticky | output | 1 | Sticky signaling-NaN status flag |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The bench sweeps every format code, with both operation kinds and both trap settings, across operands that sit on the classification edges. These include a signaling NaN whose only set bit is the lowest fraction bit, which truncates to an all-zero single fraction. A design that failed to force the quiet bit would store an infinity there. They also include an operand whose only significand bit is the integer bit, which a classifier that wrongly counts bit 63 would take for a NaN. The bench also checks that moves leave a signaling NaN signaling and leave the flag alone, which catches a design that quiets every NaN. It checks that a trapped operation writes nothing. It checks that a clear and a new signaling NaN in the same cycle leave the flag set, which catches a design that gives the clear priority.

// File: rtl/nq_pkg.sv
package nq_pkg;

    localparam int EXP_W  = 15;
    localparam int SIG_W  = 64;
    localparam int PAD_W  = 16;
    localparam int OUT_W  = 1 + EXP_W + PAD_W + SIG_W;
    localparam int QBIT   = SIG_W - 2;
    localparam int N_INT  = 3;
    localparam int N_FLT  = 2;

    typedef enum logic [2:0] {
        FMT_LONG = 3'd0,
        FMT_SGL  = 3'd1,
        FMT_EXT  = 3'd2,
        FMT_PKD  = 3'd3,
        FMT_WORD = 3'd4,
        FMT_DBL  = 3'd5,
        FMT_BYTE = 3'd6,
        FMT_RSVD = 3'd7
    } fmt_e;

    // index 0 = byte, 1 = word, 2 = long
    function automatic int int_width(input int idx);
        case (idx)
            0:       return 8;
            1:       return 16;
            default: return 32;
        endcase
    endfunction

    // index 0 = single, 1 = double
    function automatic int flt_exp_w(input int idx);
        return (idx == 0) ? 8 : 11;
    endfunction

    function automatic int flt_frac_w(input int idx);
        return (idx == 0) ? 23 : 52;
    endfunction

    typedef struct packed {
        logic [OUT_W-1:0] data;
        logic             valid;
        logic             sticky;
        logic             trap;
    } nq_state_t;

endpackage

// File: rtl/nq_classify.sv
module nq_classify
    import nq_pkg::*;
(
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0] sig_i,
    output logic             is_nan_o,
    output logic             is_snan_o
);

    logic exp_ones;
    logic quiet;
    logic low_nz;

    always_comb begin
        exp_ones  = &exp_i;
        quiet     = sig_i[QBIT];
        low_nz    = |sig_i[QBIT-1:0];
        is_nan_o  = exp_ones && (quiet || low_nz);
        is_snan_o = exp_ones && !quiet && low_nz;
    end

endmodule

// File: rtl/nq_pack.sv
module nq_pack
    import nq_pkg::*;
(
    input  logic             sign_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0] sig_i,
    input  fmt_e             fmt_i,
    input  logic             force_quiet_i,
    output logic [OUT_W-1:0] data_o
);

    localparam logic [SIG_W-1:0] QMASK = SIG_W'(1) << QBIT;

    logic [SIG_W-1:0] sig_w;
    logic [OUT_W-1:0] ext_w;
    logic [OUT_W-1:0] int_w [N_INT];
    logic [OUT_W-1:0] flt_w [N_FLT];

    assign sig_w = force_quiet_i ? (sig_i | QMASK) : sig_i;
    assign ext_w = {sign_i, exp_i, {PAD_W{1'b0}}, sig_w};

    for (genvar g = 0; g < N_INT; g++) begin : g_int
        localparam int IW = int_width(g);
        assign int_w[g] = {sig_w[SIG_W-1 -: IW], {(OUT_W-IW){1'b0}}};
    end

    for (genvar g = 0; g < N_FLT; g++) begin : g_flt
        localparam int EW = flt_exp_w(g);
        localparam int FW = flt_frac_w(g);
        assign flt_w[g] = {sign_i, {EW{1'b1}}, sig_w[QBIT -: FW],
                           {(OUT_W-1-EW-FW){1'b0}}};
    end

    always_comb begin
        case (fmt_i)
            FMT_BYTE: data_o = int_w[0];
            FMT_WORD: data_o = int_w[1];
            FMT_LONG: data_o = int_w[2];
            FMT_SGL:  data_o = flt_w[0];
            FMT_DBL:  data_o = flt_w[1];
            default:  data_o = ext_w;
        endcase
    end

endmodule

// File: rtl/nan_quiet_unit.sv
module nan_quiet_unit
    import nq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_sign,
    input  logic [14:0]       op_exp,
    input  logic [63:0]       op_sig,
    input  logic [2:0]        dst_fmt,
    input  logic              arith_op,
    input  logic              snan_trap_en,
    input  logic              clr_status,
    output logic [95:0]       res_data,
    output logic              res_valid,
    output logic              snan_sticky,
    output logic              trap_req
);

    logic             is_nan;
    logic             is_snan;
    logic [OUT_W-1:0] packed_w;
    logic             snan_arith;
    nq_state_t        st_d;
    nq_state_t        st_q;

    nq_classify u_classify (
        .exp_i     (op_exp),
        .sig_i     (op_sig),
        .is_nan_o  (is_nan),
        .is_snan_o (is_snan)
    );

    nq_pack u_pack (
        .sign_i        (op_sign),
        .exp_i         (op_exp),
        .sig_i         (op_sig),
        .fmt_i         (fmt_e'(dst_fmt)),
        .force_quiet_i (arith_op),
        .data_o        (packed_w)
    );

    assign snan_arith = in_valid && is_snan && arith_op;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.trap  = 1'b0;
        if (clr_status) begin
            st_d.sticky = 1'b0;
        end
        if (snan_arith) begin
            st_d.sticky = 1'b1;
            st_d.trap   = snan_trap_en;
        end
        if (in_valid && is_nan && !(snan_arith && snan_trap_en)) begin
            st_d.valid = 1'b1;
            st_d.data  = packed_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_data    = st_q.data;
    assign res_valid   = st_q.valid;
    assign snan_sticky = st_q.sticky;
    assign trap_req    = st_q.trap;

endmodule

// File: rtl/nq_checker.sv
module nq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       arith_op,
    input logic       snan_trap_en,
    input logic       clr_status,
    input logic [2:0] dst_fmt,
    input logic       quiet_bit,
    input logic       res_valid,
    input logic       snan_sticky,
    input logic       trap_req
);

    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !res_valid); // R7

    AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(in_valid && arith_op && snan_trap_en)); // R7

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(snan_sticky) && !$past(clr_status)) |-> snan_sticky); // R5

    AST_MOVE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && !arith_op) && !$past(snan_sticky)) |-> !snan_sticky); // R6

    AST_VALID_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid)); // R8

    AST_EXT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(arith_op) && ($past(dst_fmt) == 3'd2 || $past(dst_fmt) == 3'd3))
        |-> quiet_bit); // R9

endmodule

bind nan_quiet_unit nq_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .arith_op     (arith_op),
    .snan_trap_en (snan_trap_en),
    .clr_status   (clr_status),
    .dst_fmt      (dst_fmt),
    .quiet_bit    (res_data[62]),
    .res_valid    (res_valid),
    .snan_sticky  (snan_sticky),
    .trap_req     (trap_req)
);

// File: tb/nan_quiet_unit_tb_top.sv
`timescale 1ns/1ps
module nan_quiet_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sign = 1'b0;
    logic [14:0] op_exp = '0;
    logic [63:0] op_sig = '0;
    logic [2:0]  dst_fmt = '0;
    logic        arith_op = 1'b0;
    logic        snan_trap_en = 1'b0;
    logic        clr_status = 1'b0;
    logic [95:0] res_data;
    logic        res_valid;
    logic        snan_sticky;
    logic        trap_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nan_quiet_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sign(op_sign),
        .op_exp(op_exp), .op_sig(op_sig), .dst_fmt(dst_fmt), .arith_op(arith_op),
        .snan_trap_en(snan_trap_en), .clr_status(clr_status), .res_data(res_data),
        .res_valid(res_valid), .snan_sticky(snan_sticky), .trap_req(trap_req)
    );

    task automatic check(input bit ok, input string req, input logic [95:0] act,
                         input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [95:0] model(input logic s, input logic [14:0] e,
                                          input logic [63:0] sg, input int fmt,
                                          input bit arith);
        logic [63:0] q;
        logic [95:0] r;
        q = arith ? (sg | (64'd1 << 62)) : sg;
        case (fmt)
            0: r = 96'(q >> 32) << 64;
            4: r = 96'(q >> 48) << 80;
            6: r = 96'(q >> 56) << 88;
            1: r = ((96'(s) << 31) | (96'hFF << 23) | 96'((q >> 40) & 64'h7F_FFFF)) << 64;
            5: r = ((96'(s) << 63) | (96'h7FF << 52) | 96'((q >> 11) & 64'hF_FFFF_FFFF_FFFF)) << 32;
            default: r = (96'(s) << 95) | (96'(e) << 80) | 96'(q);
        endcase
        return r;
    endfunction

    task automatic apply(input logic s, input logic [14:0] e, input logic [63:0] sg,
                         input int fmt, input bit arith, input bit trap, input bit clr);
        @(negedge clk);
        in_valid = 1'b1; op_sign = s; op_exp = e; op_sig = sg;
        dst_fmt = 3'(fmt); arith_op = arith; snan_trap_en = trap; clr_status = clr;
        @(negedge clk);
        in_valid = 1'b0; clr_status = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
    endtask

    logic [63:0] pat_sig [8];
    logic [14:0] pat_exp [8];

    initial begin
        pat_exp[0] = 15'h7FFF; pat_sig[0] = 64'h0000_0000_0000_0001; // snan, low bit only
        pat_exp[1] = 15'h7FFF; pat_sig[1] = 64'hA000_0000_0000_1234; // snan, integer bit set
        pat_exp[2] = 15'h7FFF; pat_sig[2] = 64'h3FFF_FFFF_FFFF_FFFF; // snan, all low bits
        pat_exp[3] = 15'h7FFF; pat_sig[3] = 64'hC000_0000_0000_0000; // qnan
        pat_exp[4] = 15'h7FFF; pat_sig[4] = 64'h4ABC_DEF0_1234_5678; // qnan, no integer bit
        pat_exp[5] = 15'h7FFF; pat_sig[5] = 64'h8000_0000_0000_0000; // infinity
        pat_exp[6] = 15'h3FFF; pat_sig[6] = 64'h8000_0000_0000_0001; // normal
        pat_exp[7] = 15'h7FFE; pat_sig[7] = 64'h0000_0000_0000_0001; // exponent one short
    end

    initial begin
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0 && trap_req == 1'b0 && snan_sticky == 1'b0,
              "R10 outputs in reset", {93'd0, res_valid, trap_req, snan_sticky}, 96'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_data == 96'd0, "R10 data after reset", res_data, 96'd0);

        for (int p = 0; p < 8; p++) begin
            for (int f = 0; f < 8; f++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int t = 0; t < 2; t++) begin
                        for (int sg = 0; sg < 2; sg++) begin
                            logic [63:0] sv;
                            logic [14:0] ev;
                            bit nan, snan, exp_trap, exp_valid, exp_flag;
                            logic [95:0] exp_d;
                            sv = pat_sig[p];
                            ev = pat_exp[p];
                            nan  = (ev == 15'h7FFF) && ((sv & 64'h7FFF_FFFF_FFFF_FFFF) != 0);
                            snan = nan && !sv[62];
                            exp_trap  = snan && a == 1 && t == 1;
                            exp_valid = nan && !exp_trap;
                            exp_flag  = snan && a == 1;
                            exp_d = model(sg[0], ev, sv, f, a == 1);
                            clear_flag();
                            apply(sg[0], ev, sv, f, a == 1, t == 1, 1'b0);
                            // one register stage: outputs visible at this negedge
                            check(res_valid == exp_valid, "R1 R7 R8 res_valid",
                                  96'(res_valid), 96'(exp_valid));
                            check(trap_req == exp_trap, "R7 R6 R4 trap_req",
                                  96'(trap_req), 96'(exp_trap));
                            check(snan_sticky == exp_flag, "R5 R6 R4 sticky set",
                                  96'(snan_sticky), 96'(exp_flag));
                            if (exp_valid) begin
                                check(res_data == exp_d, (a == 1) ?
                                      "R2 R3 R9 quieted result" : "R6 move copies bits",
                                      res_data, exp_d);
                            end
                            @(negedge clk);
                            check(res_valid == 1'b0 && trap_req == 1'b0,
                                  "R8 R7 single-cycle pulses",
                                  {94'd0, res_valid, trap_req}, 96'd0);
                            check(snan_sticky == exp_flag, "R5 sticky holds",
                                  96'(snan_sticky), 96'(exp_flag));
                        end
                    end
                end
            end
        end

        // R5: set and clear in the same cycle, set wins
        clear_flag();
        apply(1'b0, 15'h7FFF, 64'h1, 2, 1'b1, 1'b0, 1'b1);
        check(snan_sticky == 1'b1, "R5 set wins over clear", 96'(snan_sticky), 96'd1);
        // R5: flag survives later quiet NaN and move operations
        apply(1'b0, 15'h7FFF, 64'hC000_0000_0000_0000, 1, 1'b1, 1'b0, 1'b0);
        apply(1'b0, 15'h7FFF, 64'h1, 6, 1'b0, 1'b0, 1'b0);
        check(snan_sticky == 1'b1, "R5 flag sticky across ops", 96'(snan_sticky), 96'd1);
        // R5: clear takes effect one cycle later
        @(negedge clk);
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
        check(snan_sticky == 1'b0, "R5 clear", 96'(snan_sticky), 96'd0);
        // R8: back-to-back operands each give a strobe
        @(negedge clk);
        in_valid = 1'b1; op_exp = 15'h7FFF; op_sig = 64'h1; dst_fmt = 3'd6;
        arith_op = 1'b1; snan_trap_en = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b1 && res_data == {8'h40, 88'd0}, "R8 R3 first of pair",
              res_data, {8'h40, 88'd0});
        op_sig = 64'hC100_0000_0000_0000; dst_fmt = 3'd4;
        @(negedge clk);
        in_valid = 1'b0;
        check(res_valid == 1'b1 && res_data == {16'hC100, 80'd0}, "R8 R4 second of pair",
              res_data, {16'hC100, 80'd0});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        done = 1'b1;
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule